// File: doc/BRIEF.md
# Four-Phase Parallel Bus Master

This block converts single-byte read and write commands from a local requester into transactions on an asynchronous parallel bus. The bus uses a full four-phase handshake: an active-low request strobe driven by this block, and an acknowledge returned by the target. The requester supplies a one-cycle start pulse, a read/write select, an address and a write byte. It receives a one-cycle done pulse and, for reads, the byte fetched from the target.

Each transaction is ordered so that nothing races against the strobe. The address, the read/write level and any write data are settled one full cycle before the request falls. For writes, the block releases the data bus on the same edge that raises the request. The next command cannot start until the target has dropped its acknowledge. As a result, the shared data pins never have two drivers. The acknowledge crosses into the local clock through a synchroniser. A programmable cycle limit abandons a transaction when the target stops responding.

The data bus is brought out as separate output, output-enable and input pins. The pad ring merges them into one bidirectional pin.

Top module: `strobe_bus_master`

## Requirements
- R1: After reset, and whenever no transaction is in progress, `busReqN` is 1, `busDataOe` is 0, and `done` and `timeoutErr` are 0.
- R2: For a write (`cmdRead`=0), `busAddr`, `busDataOut`=`cmdWdata`, `busDataOe`=1 and `busRnW`=0 are all present at least one cycle before `busReqN` falls. They stay unchanged while `busReqN` is 0.
- R3: For a read (`cmdRead`=1), `busRnW` is 1 and `busDataOe` is 0 for the whole time `busReqN` is 0.
- R4: Once `busReqN` falls, it stays 0 until the acknowledge has been high for at least the two synchroniser cycles.
- R5: When the synchronised acknowledge is high, `busReqN` rises and `busDataOe` goes to 0 on the same edge. For a read, `busDataIn` is captured on that edge.
- R6: `done` is a single-cycle pulse raised after the acknowledge has returned to 0. At that point `rdData` holds the byte captured by the latest read. Writes leave `rdData` unchanged.
- R7: Neither `done` nor a new request occurs while the acknowledge is still high.
- R8: A `cmdStart` pulse that arrives while a transaction is in progress is ignored: no second bus transaction follows.
- R9: If no acknowledge arrives, `busReqN` stays 0 for exactly `timeoutLimit`+1 cycles and then returns to 1. At that point `busDataOe` is 0, `timeoutErr` pulses for one cycle and `done` is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdStart | input | 1 | One-cycle command pulse |
| cmdRead | input | 1 | 1 = read, 0 = write |
| cmdAddr | input | ADDR_W (16) | Target byte address |
| cmdWdata | input | DATA_W (8) | Byte to write |
| timeoutLimit | input | TMO_W (16) | Cycles to wait for acknowledge before aborting |
| rdData | output | DATA_W (8) | Byte returned by the latest read |
| done | output | 1 | One-cycle completion pulse |
| timeoutErr | output | 1 | One-cycle abort pulse |
| busAddr | output | ADDR_W (16) | Address lines |
| busRnW | output | 1 | Direction level: 1 read, 0 write |
| busReqN | output | 1 | Active-low request strobe |
| busDataOut | output | DATA_W (8) | Data bus output value |
| busDataOe | output | 1 | Data bus output enable |
| busDataIn | input | DATA_W (8) | Data bus input value |
| busAck | input | 1 | Asynchronous acknowledge from target |

## Verification
The hardest situation to reach is a second start pulse landing in the middle of a live handshake. It only matters when the target is slow enough that the request is still low. The stimulus issues a command and then fires a conflicting start two cycles later, while the synchroniser guarantees the block is still waiting. It then counts the target-side transactions and checks that only one took place.

The bus target model also delays both acknowledge edges by random amounts. This makes the window between the request rising and the acknowledge falling vary. Any early `done` or early release of the bus shows up as a conflict with the target still driving.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT_HI,
    ST_WAIT_LO
  } sbmState_t;

  typedef struct packed {
    logic loadCmd;
    logic reqAssert;
    logic reqRelease;
    logic capture;
    logic waitCount;
    logic flagDone;
    logic flagErr;
  } sbmStrobes_t;
endpackage

// File: rtl/sbm_datapath.sv
module sbm_datapath
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int TMO_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbmStrobes_t       strobes,
  input  logic              cmdRead,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [TMO_W-1:0]  timeoutLimit,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRnW,
  output logic              busReqN,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              timeoutErr,
  output logic              ackSeen,
  output logic              timedOut
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] ackPipe;
  logic [TMO_W-1:0]  waitCnt;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ackPipe <= '0;
        else       ackPipe <= {ackPipe[SYNC_MSB-1:0], busAck};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ackPipe <= '0;
        else       ackPipe <= busAck;
      end
    end
  endgenerate

  assign ackSeen  = ackPipe[SYNC_MSB];
  assign timedOut = (waitCnt == timeoutLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr    <= '0;
      busRnW     <= 1'b1;
      busDataOut <= '0;
      busDataOe  <= 1'b0;
      busReqN    <= 1'b1;
    end else begin
      if (strobes.loadCmd) begin
        busAddr    <= cmdAddr;
        busRnW     <= cmdRead;
        busDataOut <= cmdWdata;
        busDataOe  <= !cmdRead;
      end else if (strobes.reqRelease) begin
        busDataOe  <= 1'b0;
      end
      if (strobes.reqAssert)       busReqN <= 1'b0;
      else if (strobes.reqRelease) busReqN <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       waitCnt <= '0;
    else if (strobes.reqAssert || strobes.reqRelease) waitCnt <= '0;
    else if (strobes.waitCount)                       waitCnt <= waitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData     <= '0;
      done       <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      if (strobes.capture) rdData <= busDataIn;
      done       <= strobes.flagDone;
      timeoutErr <= strobes.flagErr;
    end
  end
endmodule

// File: rtl/sbm_control.sv
module sbm_control
  import sbm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdStart,
  input  logic        isRead,
  input  logic        ackSeen,
  input  logic        timedOut,
  output sbmStrobes_t strobes
);
  sbmState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobes   = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdStart) begin
          strobes.loadCmd = 1'b1;
          nextState       = ST_SETUP;
        end
      end
      ST_SETUP: begin
        strobes.reqAssert = 1'b1;
        nextState         = ST_WAIT_HI;
      end
      ST_WAIT_HI: begin
        strobes.waitCount = 1'b1;
        if (ackSeen) begin
          strobes.reqRelease = 1'b1;
          strobes.capture    = isRead;
          nextState          = ST_WAIT_LO;
        end else if (timedOut) begin
          strobes.reqRelease = 1'b1;
          strobes.flagErr    = 1'b1;
          nextState          = ST_IDLE;
        end
      end
      ST_WAIT_LO: begin
        strobes.waitCount = 1'b1;
        if (!ackSeen) begin
          strobes.flagDone = 1'b1;
          nextState        = ST_IDLE;
        end else if (timedOut) begin
          strobes.flagErr = 1'b1;
          nextState       = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/strobe_bus_master.sv
module strobe_bus_master
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int TMO_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdRead,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [TMO_W-1:0]  timeoutLimit,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              timeoutErr,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRnW,
  output logic              busReqN,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busAck
);
  sbmStrobes_t strobes;
  logic        ackSeen;
  logic        timedOut;

  sbm_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdStart (cmdStart),
    .isRead   (busRnW),
    .ackSeen  (ackSeen),
    .timedOut (timedOut),
    .strobes  (strobes)
  );

  sbm_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .TMO_W       (TMO_W),
    .SYNC_STAGES (2)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .cmdRead      (cmdRead),
    .cmdAddr      (cmdAddr),
    .cmdWdata     (cmdWdata),
    .timeoutLimit (timeoutLimit),
    .busAck       (busAck),
    .busDataIn    (busDataIn),
    .busAddr      (busAddr),
    .busRnW       (busRnW),
    .busReqN      (busReqN),
    .busDataOut   (busDataOut),
    .busDataOe    (busDataOe),
    .rdData       (rdData),
    .done         (done),
    .timeoutErr   (timeoutErr),
    .ackSeen      (ackSeen),
    .timedOut     (timedOut)
  );
endmodule

// File: rtl/strobe_bus_master_chk.sv
module strobe_bus_master_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReqN,
  input logic              busRnW,
  input logic              busDataOe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busDataOut,
  input logic              done,
  input logic              timeoutErr
);
  // R3
  read_never_drives_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> !busRnW);

  // R2
  setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReqN) |-> ($stable(busAddr) && $stable(busRnW) && $stable(busDataOut) && $stable(busDataOe)));

  // R2
  held_while_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busReqN && !$fell(busReqN)) |-> ($stable(busAddr) && $stable(busRnW) && $stable(busDataOut)));

  // R5
  release_with_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReqN) |-> !busDataOe);

  // R7
  done_bus_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busReqN && !busDataOe));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  err_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> !timeoutErr);

  // R9
  err_not_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timeoutErr));
endmodule

bind strobe_bus_master strobe_bus_master_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busReqN    (busReqN),
  .busRnW     (busRnW),
  .busDataOe  (busDataOe),
  .busAddr    (busAddr),
  .busDataOut (busDataOut),
  .done       (done),
  .timeoutErr (timeoutErr)
);

// File: tb/sim_strobe_bus_master.sv
`timescale 1ns/1ps
module sim_strobe_bus_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStart = 1'b0;
  logic        cmdRead = 1'b0;
  logic [15:0] cmdAddr = '0;
  logic [7:0]  cmdWdata = '0;
  logic [15:0] timeoutLimit = 16'd60;
  logic [7:0]  rdData;
  logic        done, timeoutErr;
  logic [15:0] busAddr;
  logic        busRnW, busReqN, busDataOe;
  logic [7:0]  busDataOut, busDataIn;
  logic        busAck = 1'b0;

  logic        slaveDrive = 1'b0;
  logic [7:0]  slaveData = '0;
  logic        noAck = 1'b0;
  int          txnCount = 0;
  logic        expRead;
  logic [15:0] expAddr;
  logic [7:0]  expWdata;
  logic [7:0]  slaveMem [256];
  logic [7:0]  refMem [256];
  logic [7:0]  lastRead = '0;
  int          checks = 0;
  int          failures = 0;

  always #4 clk = ~clk;

  assign busDataIn = slaveDrive ? slaveData : 8'hEE;

  strobe_bus_master u0 (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdRead(cmdRead),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .timeoutLimit(timeoutLimit),
    .rdData(rdData), .done(done), .timeoutErr(timeoutErr),
    .busAddr(busAddr), .busRnW(busRnW), .busReqN(busReqN),
    .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busDataIn(busDataIn), .busAck(busAck)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] initByte(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  // Bus target model
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && !busReqN) begin
        txnCount++;
        chk(busAddr == expAddr, "R2 address presented", 32'(busAddr), 32'(expAddr));
        chk(busRnW == expRead, "R2/R3 direction level", 32'(busRnW), 32'(expRead));
        chk(busDataOe == !expRead, "R2/R3 data enable", 32'(busDataOe), 32'(!expRead));
        if (!expRead) chk(busDataOut == expWdata, "R2 write byte", 32'(busDataOut), 32'(expWdata));
        if (noAck) begin
          while (!busReqN) @(negedge clk);
        end else begin
          repeat ($urandom_range(0, 5)) @(negedge clk);
          chk(busReqN == 1'b0, "R4 request held before ack", 32'(busReqN), 32'd0);
          if (busRnW) begin
            slaveData  = slaveMem[busAddr[7:0]];
            slaveDrive = 1'b1;
          end else begin
            slaveMem[busAddr[7:0]] = busDataOut;
          end
          busAck = 1'b1;
          begin
            int hold = 0;
            @(negedge clk);
            while (!busReqN) begin
              hold++;
              if (slaveDrive) chk(busDataOe == 1'b0, "R3 single driver", 32'(busDataOe), 32'd0);
              @(negedge clk);
            end
            chk(hold >= 1, "R4 request low through sync", 32'(hold), 32'd1);
          end
          chk(busDataOe == 1'b0, "R5 data released with request", 32'(busDataOe), 32'd0);
          repeat ($urandom_range(0, 6)) begin
            @(negedge clk);
            chk(busReqN == 1'b1 && done == 1'b0, "R7 nothing before ack falls", {busReqN, done}, 32'h2);
          end
          slaveDrive = 1'b0;
          busAck = 1'b0;
        end
      end
    end
  end

  task automatic runCmd(input bit rd, input logic [15:0] a, input logic [7:0] wd, input bit extra);
    int startTx, n;
    expRead = rd; expAddr = a; expWdata = wd;
    startTx = txnCount;
    @(negedge clk);
    cmdRead = rd; cmdAddr = a; cmdWdata = wd; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    if (extra) begin
      repeat (2) @(negedge clk);
      cmdRead = !rd; cmdAddr = a ^ 16'h00FF; cmdWdata = ~wd; cmdStart = 1'b1;
      @(negedge clk);
      cmdStart = 1'b0;
    end
    n = 0;
    while (!done && !timeoutErr && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R6 done raised", 32'(done), 32'd1);
    chk(busAck == 1'b0, "R7 done after ack low", 32'(busAck), 32'd0);
    if (rd) begin
      chk(rdData == refMem[a[7:0]], "R5 read capture", 32'(rdData), 32'(refMem[a[7:0]]));
      lastRead = refMem[a[7:0]];
    end else begin
      refMem[a[7:0]] = wd;
      chk(rdData == lastRead, "R6 write leaves read result", 32'(rdData), 32'(lastRead));
    end
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", 32'(done), 32'd0);
    chk(busReqN == 1'b1 && busDataOe == 1'b0, "R1 idle after done", {busReqN, busDataOe}, 32'h2);
    if (extra) begin
      repeat (10) @(negedge clk);
      chk(txnCount == startTx + 1, "R8 busy start ignored", 32'(txnCount), 32'(startTx + 1));
      chk(busReqN == 1'b1, "R8 no second request", 32'(busReqN), 32'd1);
    end
  endtask

  initial begin
    int lowCnt, n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      slaveMem[i] = initByte(i);
      refMem[i]   = initByte(i);
    end
    repeat (3) @(negedge clk);
    chk(busReqN == 1'b1 && busDataOe == 1'b0 && done == 1'b0 && timeoutErr == 1'b0,
        "R1 reset state", {busReqN, busDataOe, done, timeoutErr}, 32'h8);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(busReqN == 1'b1 && busDataOe == 1'b0, "R1 idle after reset", {busReqN, busDataOe}, 32'h2);

    // Directed corners
    runCmd(1'b1, 16'h1820, 8'h00, 1'b0);
    runCmd(1'b0, 16'h1820, 8'h00, 1'b0);
    runCmd(1'b1, 16'h1820, 8'h00, 1'b0);
    runCmd(1'b0, 16'hFF21, 8'hFF, 1'b0);
    runCmd(1'b1, 16'hFF21, 8'h00, 1'b0);
    runCmd(1'b0, 16'h0033, 8'hA5, 1'b1);
    runCmd(1'b1, 16'h0033, 8'h00, 1'b1);

    // Random traffic
    for (int k = 0; k < 60; k++) begin
      logic [15:0] a;
      a = {8'($urandom), 4'h0, 4'($urandom)};
      runCmd(1'($urandom), a, 8'($urandom), 1'b0);
    end

    // Timeout: target never acknowledges
    timeoutLimit = 16'd12;
    noAck = 1'b1;
    expRead = 1'b0; expAddr = 16'h4410; expWdata = 8'h3C;
    @(negedge clk);
    cmdRead = 1'b0; cmdAddr = 16'h4410; cmdWdata = 8'h3C; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    lowCnt = 0; n = 0;
    while (!timeoutErr && n < 400) begin
      if (!busReqN) lowCnt++;
      @(negedge clk);
      n++;
    end
    chk(timeoutErr == 1'b1, "R9 abort pulse", 32'(timeoutErr), 32'd1);
    chk(lowCnt == 13, "R9 request low length", 32'(lowCnt), 32'd13);
    chk(busReqN == 1'b1 && busDataOe == 1'b0 && done == 1'b0, "R9 bus idle on abort",
        {busReqN, busDataOe, done}, 32'h4);
    @(negedge clk);
    chk(timeoutErr == 1'b0, "R9 abort one cycle", 32'(timeoutErr), 32'd0);
    noAck = 1'b0;
    timeoutLimit = 16'd60;

    runCmd(1'b1, 16'h0021, 8'h00, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule